// File: doc/BRIEF.md
# Serial Receiver with Two-Byte Receive Buffer

This block receives asynchronous serial characters of one start bit, eight data bits sent least significant bit first, and one stop bit. The idle line is high. A falling level on the line starts a candidate frame. The block checks that frame against a 16x sample clock, assembles the data bits in a shift register, and at the stop-bit sample moves the character into a receive buffer that holds two characters.

Software, or any other consumer, watches two level flags. One says at least one character is waiting. The other says two are waiting. The consumer pops the oldest character with a one-cycle read strobe, so it may read one character per one-full indication or two in a row when the buffer is full. Two sticky error flags report a character lost to a full buffer and a stop bit sampled low. An interrupt output merges the two buffer flags, each under its own enable.

The receive state machine has five states:

- `RX_IDLE`: waiting for a low line.
- `RX_START`: confirming the start bit at mid-bit.
- `RX_DATA`: sampling eight bits.
- `RX_STOP`: sampling the stop bit.
- `RX_HOLD`: waiting for the line to return high after a bad stop bit.

The transitions are:

- `RX_IDLE` to `RX_START`: the line is seen low on a tick.
- `RX_START` to `RX_DATA`: the line is still low at the eighth tick.
- `RX_START` to `RX_IDLE`: a glitch is rejected.
- `RX_DATA` to `RX_STOP`: the eighth bit has been taken.
- `RX_STOP` to `RX_IDLE`: the stop bit is high.
- `RX_STOP` to `RX_HOLD`: the stop bit is low.
- `RX_HOLD` to `RX_IDLE`: the line is high again.

Top module: `rxq_top`

## Requirements
- R1: After reset, `rx_busy`, `buf_one`, `buf_two`, `ovr_flag`, `frm_flag` and `irq` are all 0.
- R2: The serial input passes through a two-stage synchronizer, resetting high. A low seen in `RX_IDLE` on a sample tick enters `RX_START`. The start bit is accepted only if the synchronized line is still low at the eighth tick. Otherwise the block returns to `RX_IDLE` and stores nothing.
- R3: `rx_busy` is 1 from entry to `RX_START` until the stop-bit sample. It falls in the same cycle the character is stored.
- R4: A bit lasts OVERSAMPLE (16) ticks, with one tick every CLK_DIV clocks. Data bits are sampled at bit centre and assembled with the first received bit at bit 0 of `rd_data`.
- R5: The stop bit is sampled at the sixteenth tick of the stop period, and the character is then pushed into the buffer. `buf_one` is 1 whenever at least one character is held. `buf_two` is 1 when two are held.
- R6: `rd_data` always shows the oldest held character. A high `rd_en` for one clock removes it, and the count goes 2 to 1 to 0. `rd_en` with an empty buffer changes nothing.
- R7: A character completed while two are held, with no read in the same clock, is dropped. That sets the sticky `ovr_flag`, and the two held characters are kept. A read in the same clock makes room.
- R8: A low stop-bit sample sets the sticky `frm_flag`, and the character is still stored. The block then waits in `RX_HOLD` until the line is high before it can detect a new start.
- R9: `irq` equals (`buf_one` AND `ie_one`) OR (`buf_two` AND `ie_two`).
- R10: `clr_err` high for one clock clears both sticky flags. A flag being set in the same clock takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| rd_en | input | 1 | Pop the oldest character |
| clr_err | input | 1 | Clear the sticky error flags |
| ie_one | input | 1 | Interrupt enable for the one-full flag |
| ie_two | input | 1 | Interrupt enable for the two-full flag |
| rd_data | output | DATA_W | Oldest held character |
| rx_busy | output | 1 | Frame in progress |
| buf_one | output | 1 | At least one character held |
| buf_two | output | 1 | Two characters held |
| ovr_flag | output | 1 | Sticky overrun |
| frm_flag | output | 1 | Sticky framing error |
| irq | output | 1 | Merged, enabled buffer interrupt |

## Verification
The assertions assume `rd_en` and `clr_err` are synchronous single-clock strobes. They also assume the serial line holds each bit for a whole bit period once a start has been confirmed, so that every sample lands inside the intended bit.

The bench drives the line only on falling clock edges, in exact 16-clock bit cells with CLK_DIV set to 1. It leaves at least twenty idle-high clocks between frames and releases the line within one bit after a bad stop bit. Strobes are raised for exactly one clock, away from the cycles in which a character is stored.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;
endpackage

// File: rtl/rxq_tick.sv
`timescale 1ns/1ps
module rxq_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_DIV <= 1) begin : g_every
            logic on_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) on_q <= 1'b0;
                else        on_q <= 1'b1;
            end
            assign tick = on_q;
        end else begin : g_count
            localparam int DW = $clog2(CLK_DIV);
            localparam logic [DW-1:0] TOP = DW'(CLK_DIV - 1);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           div_q <= '0;
                else if (div_q == TOP) div_q <= '0;
                else                  div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == TOP);
        end
    endgenerate
endmodule

// File: rtl/rxq_frame.sv
`timescale 1ns/1ps
module rxq_frame
    import rxq_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    output logic              busy_o,
    output logic              push_o,
    output logic              stop_bad_o,
    output logic [DATA_W-1:0] push_data_o
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST_T = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] MID_T  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [BW-1:0] LAST_B = BW'(DATA_W - 1);

    rx_state_e         st, st_n;
    logic [CW-1:0]     cnt, cnt_n;
    logic [BW-1:0]     bitn, bitn_n;
    logic [DATA_W-1:0] sh, sh_n;
    logic              push_n, bad_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            bitn <= bitn_n;
            sh   <= sh_n;
        end
    end

    // transitions
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        bitn_n = bitn;
        sh_n   = sh;
        push_n = 1'b0;
        bad_n  = 1'b0;
        unique case (st)
            RX_IDLE: begin
                if (tick && !rx_s) begin
                    st_n  = RX_START;
                    cnt_n = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (cnt == MID_T) begin
                        cnt_n  = '0;
                        bitn_n = '0;
                        st_n   = rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (cnt == LAST_T) begin
                        cnt_n = '0;
                        sh_n  = {rx_s, sh[DATA_W-1:1]};
                        if (bitn == LAST_B) st_n = RX_STOP;
                        else                bitn_n = bitn + 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (cnt == LAST_T) begin
                        cnt_n  = '0;
                        push_n = 1'b1;
                        bad_n  = !rx_s;
                        st_n   = rx_s ? RX_IDLE : RX_HOLD;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            RX_HOLD: begin
                if (rx_s) st_n = RX_IDLE;
            end
            default: st_n = RX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o      = (st == RX_START) || (st == RX_DATA) || (st == RX_STOP);
        push_o      = push_n;
        stop_bad_o  = bad_n;
        push_data_o = sh;
    end

    // R3: storing a character ends the busy window
    a_r3_push_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !busy_o);
    // R2: a start bit that is high again at mid-bit is rejected
    a_r2_reject_glitch: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_START && tick && cnt == MID_T && rx_s) |=> (st == RX_IDLE));
    // R8: after a bad stop bit no start is seen until the line is high
    a_r8_hold_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_HOLD && !rx_s) |=> !busy_o);
endmodule

// File: rtl/rxq_fifo2.sv
`timescale 1ns/1ps
module rxq_fifo2 #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop_req,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        count,
    output logic              drop
);
    logic [DATA_W-1:0] head, tail;
    logic              pop, take;

    assign pop   = pop_req && (count != 2'd0);
    assign take  = push && ((count != 2'd2) || pop);
    assign drop  = push && !take;
    assign rdata = head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= 2'd0;
        end else begin
            unique case ({pop, take})
                2'b10: begin
                    head  <= tail;
                    count <= count - 2'd1;
                end
                2'b01: begin
                    if (count == 2'd0) head <= wdata;
                    else               tail <= wdata;
                    count <= count + 2'd1;
                end
                2'b11: begin
                    if (count == 2'd1) begin
                        head <= wdata;
                    end else begin
                        head <= tail;
                        tail <= wdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: a push with room and no read grows the count by one
    a_r5_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_req && count != 2'd2) |=> (count == $past(count) + 2'd1));
    // R6: a read of an empty buffer leaves it empty
    a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && count == 2'd0 && !push) |=> (count == 2'd0));
    // R7: a third character leaves both held entries untouched
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_req && count == 2'd2) |=> (count == 2'd2 && $stable(head) && $stable(tail)));
endmodule

// File: rtl/rxq_top.sv
`timescale 1ns/1ps
module rxq_top #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16,
    parameter int CLK_DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              rd_en,
    input  logic              clr_err,
    input  logic              ie_one,
    input  logic              ie_two,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_busy,
    output logic              buf_one,
    output logic              buf_two,
    output logic              ovr_flag,
    output logic              frm_flag,
    output logic              irq
);
    logic              sy1, sy2, tick;
    logic              push, bad, drop;
    logic [DATA_W-1:0] pdata;
    logic [1:0]        count;
    logic              ovr_q, frm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy1 <= 1'b1;
            sy2 <= 1'b1;
        end else begin
            sy1 <= rx_in;
            sy2 <= sy1;
        end
    end

    rxq_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    rxq_frame #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(sy2),
        .busy_o(rx_busy), .push_o(push), .stop_bad_o(bad), .push_data_o(pdata)
    );

    rxq_fifo2 #(.DATA_W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(pdata),
        .pop_req(rd_en), .rdata(rd_data), .count(count), .drop(drop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            frm_q <= 1'b0;
        end else begin
            if (drop)         ovr_q <= 1'b1;
            else if (clr_err) ovr_q <= 1'b0;
            if (bad)          frm_q <= 1'b1;
            else if (clr_err) frm_q <= 1'b0;
        end
    end

    assign buf_one  = (count != 2'd0);
    assign buf_two  = (count == 2'd2);
    assign ovr_flag = ovr_q;
    assign frm_flag = frm_q;
    assign irq      = (buf_one && ie_one) || (buf_two && ie_two);

    // R8: the framing flag stays set until cleared
    a_r8_ferr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q && !clr_err) |=> frm_q);
    // R10: a clear with no new error empties the overrun flag
    a_r10_clear_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !drop) |=> !ovr_q);
endmodule

// File: tb/sim_rxq_top.sv
`timescale 1ns/1ps
module sim_rxq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       rd_en = 1'b0;
    logic       clr_err = 1'b0;
    logic       ie_one = 1'b0;
    logic       ie_two = 1'b0;
    logic [7:0] rd_data;
    logic       rx_busy, buf_one, buf_two, ovr_flag, frm_flag, irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rxq_top #(.DATA_W(8), .OVERSAMPLE(16), .CLK_DIV(1)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rd_en(rd_en),
        .clr_err(clr_err), .ie_one(ie_one), .ie_two(ie_two),
        .rd_data(rd_data), .rx_busy(rx_busy), .buf_one(buf_one),
        .buf_two(buf_two), .ovr_flag(ovr_flag), .frm_flag(frm_flag), .irq(irq)
    );

    // behavioural reference
    int         cyc = 0;
    logic [7:0] q[$];
    bit         m_ovr = 0, m_ferr = 0;
    int         pend_at = -1, busy_lo = -1, busy_hi = -1;
    logic [7:0] pend_data;
    bit         pend_bad;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            q.delete();
            m_ovr = 0;
            m_ferr = 0;
        end else begin
            if (rd_en && q.size() > 0) void'(q.pop_front());
            if (clr_err) begin
                m_ovr = 0;
                m_ferr = 0;
            end
            if (cyc == pend_at) begin
                if (q.size() < 2) q.push_back(pend_data);
                else m_ovr = 1;
                if (pend_bad) m_ferr = 1;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            bit eb, e1, e2, ei;
            eb = (cyc >= busy_lo) && (cyc < busy_hi);
            e1 = (q.size() > 0);
            e2 = (q.size() == 2);
            ei = (e1 && ie_one) || (e2 && ie_two);
            chk(rx_busy == eb, "R3 busy", rx_busy, eb);
            chk(buf_one == e1, "R5 one-full", buf_one, e1);
            chk(buf_two == e2, "R5 two-full", buf_two, e2);
            chk(ovr_flag == m_ovr, "R7 overrun", ovr_flag, m_ovr);
            chk(frm_flag == m_ferr, "R8 framing", frm_flag, m_ferr);
            chk(irq == ei, "R9 irq", irq, ei);
            if (e1) chk(rd_data == q[0], "R6 head", rd_data, q[0]);
        end
    end

    task automatic send(input logic [7:0] b, input bit stop_ok);
        @(negedge clk);
        rx_in     = 1'b0;
        pend_data = b;
        pend_bad  = !stop_ok;
        busy_lo   = cyc + 3;
        busy_hi   = cyc + 155;
        pend_at   = cyc + 155;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = b[i];
            repeat (16) @(negedge clk);
        end
        rx_in = stop_ok;
        repeat (16) @(negedge clk);
        rx_in = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic glitch();
        @(negedge clk);
        rx_in   = 1'b0;
        busy_lo = cyc + 3;
        busy_hi = cyc + 11;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk({rx_busy, buf_one, buf_two, ovr_flag, frm_flag, irq} == 6'b0, "R1 reset",
            {rx_busy, buf_one, buf_two, ovr_flag, frm_flag, irq}, 0);

        // R4 single character, LSB first
        send(8'hA5, 1'b1);
        chk(rd_data == 8'hA5, "R4 data", rd_data, 8'hA5);
        chk(buf_one && !buf_two, "R5 one held", {buf_one, buf_two}, 2'b10);
        ie_one = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq one", irq, 1);
        pulse_rd();
        chk(!buf_one, "R6 empty after read", buf_one, 0);

        // R2 glitch rejected
        glitch();
        chk(!buf_one && !rx_busy, "R2 glitch", {buf_one, rx_busy}, 0);

        // two characters, read twice
        ie_one = 1'b0;
        ie_two = 1'b1;
        send(8'h3C, 1'b1);
        send(8'h81, 1'b1);
        chk(buf_two && irq, "R5 two held", {buf_two, irq}, 2'b11);
        chk(rd_data == 8'h3C, "R6 oldest first", rd_data, 8'h3C);
        pulse_rd();
        chk(rd_data == 8'h81 && buf_one && !buf_two, "R6 second", rd_data, 8'h81);
        pulse_rd();
        pulse_rd(); // R6 read on empty
        chk(!buf_one && !buf_two, "R6 empty read ignored", {buf_one, buf_two}, 0);

        // R7 overrun
        send(8'h11, 1'b1);
        send(8'h22, 1'b1);
        send(8'h33, 1'b1);
        chk(ovr_flag && rd_data == 8'h11, "R7 third dropped", rd_data, 8'h11);
        pulse_rd();
        chk(rd_data == 8'h22, "R7 kept second", rd_data, 8'h22);
        pulse_rd();
        pulse_clr();
        chk(!ovr_flag, "R10 clear overrun", ovr_flag, 0);

        // R8 framing error then normal frame
        send(8'h5A, 1'b0);
        chk(frm_flag && rd_data == 8'h5A, "R8 bad stop stored", rd_data, 8'h5A);
        send(8'h0F, 1'b1);
        chk(buf_two, "R8 recovers after hold", buf_two, 1);
        pulse_rd();
        chk(rd_data == 8'h0F, "R4 data after error", rd_data, 8'h0F);
        pulse_rd();
        pulse_clr();
        chk(!frm_flag, "R10 clear framing", frm_flag, 0);
        repeat (10) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule